// File: doc/BRIEF.md
# Folded Four-Step 16-Point Number-Theoretic Transform

This block computes a 16-point forward number-theoretic transform over a small prime field, X_k = Σ x_n·ω^(n·k) mod q. It treats the 16 inputs as a 4×4 grid and runs the four-step method: a 4-point transform down each column, an element-wise twiddle multiply, and a second set of 4-point transforms. The block has no transpose pass and no bit-reversal pass. Both permutations are built into the way the constant tables and buffer addresses are indexed, so the second stage writes each result straight to its natural-order slot.

A host streams in 16 coefficients, one per accepted handshake, in index order. The block then runs its three arithmetic phases on one modular multiply-accumulate unit. After that it streams out the 16 results in index order. The next transform can only be loaded after the last result has been taken. The default field is q = 97, with ω = 8 as the primitive 16th root of unity. All tables are computed from these two parameters during elaboration.

Top module: `ntt16_fourstep`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and busy is 0.
- R2: A coefficient is taken on each clock edge where in_valid and in_ready are both 1. The first one taken is x_0 and the sixteenth is x_15. in_ready is 0 on the cycle after the sixteenth is taken.
- R3: The sixteen outputs, in the order they are accepted, are X_0 through X_15, where X_k = Σ_n x_n·ω^(n·k) mod q.
- R4: busy is 1 for exactly 144 cycles, starting on the cycle after the sixteenth input is taken. out_valid goes to 1 on the cycle after busy falls. While busy is 1, both in_ready and out_valid are 0.
- R5: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data keeps its value on the next cycle.
- R6: in_ready stays 0 from the start of computation until the sixteenth output has been accepted, and it returns to 1 on the next cycle. Any in_valid or in_data activity during this time has no effect on the results.
- R7: An input value of q or more is treated as its residue mod q. Every output value is less than q.
- R8: An impulse of value 1 at index m gives X_k = ω^(m·k) mod q. For m = 0 this means all outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input coefficient present |
| in_ready | output | 1 | Block can take a coefficient |
| in_data | input | W=$clog2(Q) | Input coefficient |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | W | Result value |
| busy | output | 1 | Arithmetic phases running |

## Verification
The hardest case to reach from the ports is a stalled consumer combined with a busy input side. Results have to stay frozen under backpressure, while a stray in_valid still pulses during both computation and drain. The bench reaches this by asserting junk inputs for the whole busy window and the whole output window. At the same time it withholds out_ready on a periodic pattern, and it checks every result against a direct O(N²) evaluation. It also uses non-canonical inputs of q or more, which confirm the residue behaviour that only shows up when raw inputs pass through the multiplier unreduced.

// File: rtl/ntt16_pkg.sv
package ntt16_pkg;

  typedef enum logic [2:0] {
    PH_LOAD,
    PH_COL1,
    PH_TWID,
    PH_COL2,
    PH_DRAIN
  } phase_t;

  // base^e mod m, evaluated at elaboration for table generation
  function automatic int unsigned powmod(input int unsigned base,
                                         input int unsigned e,
                                         input int unsigned m);
    longint unsigned r;
    r = 1;
    for (int unsigned i = 0; i < e; i++) r = (r * longint'(base)) % longint'(m);
    return int'(r);
  endfunction

endpackage

// File: rtl/ntt16_mac.sv
module ntt16_mac #(
  parameter int Q = 97,
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         first,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  localparam int PW = 2 * W + 1;

  logic [W-1:0]  acc;
  logic [PW-1:0] wide;

  always_comb begin
    wide = (first ? '0 : PW'(acc)) + PW'(a) * PW'(b);
    sum  = W'(wide % PW'(Q));
  end

  always_ff @(posedge clk) begin
    if (rst)     acc <= '0;
    else if (en) acc <= sum;
  end
endmodule

// File: rtl/ntt16_ctrl.sv
module ntt16_ctrl
  import ntt16_pkg::*;
#(
  parameter int SIDE = 4,
  localparam int N  = SIDE * SIDE,
  localparam int CW = $clog2(N),
  localparam int TW = $clog2(SIDE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_fire,
  input  logic          out_fire,
  output phase_t        phase,
  output logic [CW-1:0] cnt,
  output logic [TW-1:0] term,
  output logic          cnt_last,
  output logic          wr_en,
  output logic          mac_en,
  output logic          first
);
  logic term_last;
  logic dot_phase;

  assign cnt_last  = (cnt == CW'(N - 1));
  assign term_last = (term == TW'(SIDE - 1));
  assign dot_phase = (phase == PH_COL1) || (phase == PH_COL2);
  assign mac_en    = dot_phase || (phase == PH_TWID);
  assign wr_en     = (dot_phase && term_last) || (phase == PH_TWID);
  assign first     = (term == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_LOAD;
      cnt   <= '0;
      term  <= '0;
    end else begin
      case (phase)
        PH_LOAD: if (in_fire) begin
          cnt <= cnt_last ? '0 : cnt + 1'b1;
          if (cnt_last) phase <= PH_COL1;
        end
        PH_COL1, PH_COL2: begin
          term <= term_last ? '0 : term + 1'b1;
          if (term_last) begin
            cnt <= cnt_last ? '0 : cnt + 1'b1;
            if (cnt_last) phase <= (phase == PH_COL1) ? PH_TWID : PH_DRAIN;
          end
        end
        PH_TWID: begin
          cnt <= cnt_last ? '0 : cnt + 1'b1;
          if (cnt_last) phase <= PH_COL2;
        end
        PH_DRAIN: if (out_fire) begin
          cnt <= cnt_last ? '0 : cnt + 1'b1;
          if (cnt_last) phase <= PH_LOAD;
        end
        default: phase <= PH_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/ntt16_fourstep.sv
module ntt16_fourstep
  import ntt16_pkg::*;
#(
  parameter int Q     = 97,
  parameter int OMEGA = 8,
  parameter int SIDE  = 4,
  localparam int W    = $clog2(Q)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         busy
);
  localparam int N  = SIDE * SIDE;
  localparam int CW = $clog2(N);
  localparam int TW = $clog2(SIDE);

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic [TW-1:0] term;
  logic          cnt_last, wr_en, mac_en, first;
  logic          in_fire, out_fire;
  logic [W-1:0]  op_a, coef, mac_sum;
  logic [W-1:0]  out_q;

  // Small transform kernel (omega^SIDE powers) and full twiddle powers.
  logic [W-1:0] w_tab  [SIDE];
  logic [W-1:0] tw_tab [N];
  for (genvar i = 0; i < SIDE; i++) begin : g_wtab
    assign w_tab[i] = W'(powmod(OMEGA, SIDE * i, Q));
  end
  for (genvar i = 0; i < N; i++) begin : g_twtab
    assign tw_tab[i] = W'(powmod(OMEGA, i, Q));
  end

  // Working stores; no reset so they can map to RAM.
  logic [W-1:0] buf_a [N];
  logic [W-1:0] buf_b [N];

  assign in_ready  = (phase == PH_LOAD);
  assign out_valid = (phase == PH_DRAIN);
  assign busy      = (phase == PH_COL1) || (phase == PH_TWID) || (phase == PH_COL2);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign out_data  = out_q;

  ntt16_ctrl #(.SIDE(SIDE)) u_ctrl (
    .clk(clk), .rst(rst), .in_fire(in_fire), .out_fire(out_fire),
    .phase(phase), .cnt(cnt), .term(term), .cnt_last(cnt_last),
    .wr_en(wr_en), .mac_en(mac_en), .first(first)
  );

  ntt16_mac #(.Q(Q), .W(W)) u_mac (
    .clk(clk), .rst(rst), .en(mac_en), .first(first),
    .a(op_a), .b(coef), .sum(mac_sum)
  );

  // Operand and coefficient selection. cnt = SIDE*hi + lo.
  // Column pass 1: slot (k1=hi, n2=lo) = sum_n1 x[SIDE*n1+n2] * w^(k1*n1)
  // Twiddle pass : slot (k1=hi, n2=lo) *= omega^(k1*n2)
  // Column pass 2: output k with k1=lo, k2=hi = sum_n2 Z[k1][n2] * w^(n2*k2)
  always_comb begin
    int hi, lo, t;
    hi   = int'(cnt) / SIDE;
    lo   = int'(cnt) % SIDE;
    t    = int'(term);
    op_a = '0;
    coef = '0;
    case (phase)
      PH_COL1: begin
        op_a = buf_a[CW'(t * SIDE + lo)];
        coef = w_tab[TW'((hi * t) % SIDE)];
      end
      PH_TWID: begin
        op_a = buf_b[cnt];
        coef = tw_tab[CW'((hi * lo) % N)];
      end
      PH_COL2: begin
        op_a = buf_b[CW'(lo * SIDE + t)];
        coef = w_tab[TW'((t * hi) % SIDE)];
      end
      default: ;
    endcase
  end

  logic         a_we, b_we;
  logic [W-1:0] a_wd;
  assign a_we = in_fire || (wr_en && phase == PH_COL2);
  assign a_wd = in_fire ? in_data : mac_sum;
  assign b_we = wr_en && (phase == PH_COL1 || phase == PH_TWID);

  always_ff @(posedge clk) begin
    if (a_we) buf_a[cnt] <= a_wd;
    if (b_we) buf_b[cnt] <= mac_sum;
  end

  // Registered output word, preloaded as the final result is written.
  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else if (wr_en && phase == PH_COL2 && cnt_last) out_q <= buf_a[0];
    else if (out_fire && !cnt_last) out_q <= buf_a[cnt + 1'b1];
  end
endmodule

// File: rtl/ntt16_fourstep_chk.sv
module ntt16_fourstep_chk #(
  parameter int Q    = 97,
  parameter int SIDE = 4,
  parameter int W    = 7
) (
  input logic         clk,
  input logic         rst,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic         busy
);
  localparam int N        = SIDE * SIDE;
  localparam int BUSY_CYC = 2 * N * SIDE + N;

  logic [15:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (rst)       busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  assert_busy_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!in_ready && !out_valid));

  assert_busy_len_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_cnt == 16'(BUSY_CYC)));

  assert_drain_after_busy_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> out_valid);

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_sides_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));

  assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ready) |-> $past(out_valid && out_ready));

  assert_range_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(out_data) < Q));
endmodule

bind ntt16_fourstep ntt16_fourstep_chk #(.Q(Q), .SIDE(SIDE), .W(W)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .busy(busy)
);

// File: tb/ntt16_fourstep_test.sv
`timescale 1ns/1ps
module ntt16_fourstep_test;
  localparam int Q = 97, OMEGA = 8, N = 16, W = 7, BUSY_CYC = 144;
  typedef int vec_t [N];

  logic clk = 1'b0;
  logic rst, in_valid, out_ready;
  logic [W-1:0] in_data;
  logic in_ready, out_valid, busy;
  logic [W-1:0] out_data;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ntt16_fourstep uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .busy(busy)
  );

  function automatic int pw(int b, int e);
    int r = 1;
    for (int i = 0; i < e; i++) r = (r * b) % Q;
    return r;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drives one transform in, runs it, drains it, checking every result.
  task automatic run(vec_t x, int stall_mod, bit junk, string req);
    vec_t y;
    int bcnt = 0, k = 0, c = 0, held = 0;
    bit hold_pend = 0;
    for (int kk = 0; kk < N; kk++) begin
      int s = 0;
      for (int n = 0; n < N; n++) s = (s + (x[n] % Q) * pw(OMEGA, (n * kk) % N)) % Q;
      y[kk] = s;
    end
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = W'(x[i]);
      if (!in_ready) chk("R2 ready during load", 0, 1);
    end
    @(negedge clk);
    in_valid = junk;
    in_data  = W'($urandom_range(0, 127));
    chk("R2 ready low after 16th", int'(in_ready), 0);
    while (!out_valid) begin
      if (busy) bcnt++;
      if (in_ready) chk("R4 in_ready low while busy", 1, 0);
      in_data = W'($urandom_range(0, 127));
      @(negedge clk);
    end
    chk("R4 busy cycles", bcnt, BUSY_CYC);
    while (k < N) begin
      if (hold_pend) chk("R5 held data", int'(out_data), held);
      out_ready = (stall_mod == 0) ? 1'b1 : ((c % stall_mod) != 0);
      in_data   = W'($urandom_range(0, 127));
      if (in_ready) chk("R6 in_ready low while draining", 1, 0);
      hold_pend = out_valid && !out_ready;
      held      = int'(out_data);
      if (out_valid && out_ready) begin
        chk($sformatf("%s X%0d", req, k), int'(out_data), y[k]);
        k++;
      end
      c++;
      if (k < N) @(negedge clk);
    end
    in_valid = 1'b0;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R6 in_ready back after drain", int'(in_ready), 1);
  endtask

  task automatic test_reset;
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 busy", int'(busy), 0);
  endtask

  task automatic test_impulse(int m);
    vec_t x;
    for (int i = 0; i < N; i++) x[i] = (i == m) ? 1 : 0;
    run(x, 0, 0, $sformatf("R8 impulse m=%0d", m));
  endtask

  task automatic test_random(int stall_mod);
    vec_t x;
    for (int i = 0; i < N; i++) x[i] = $urandom_range(0, Q - 1);
    run(x, stall_mod, 0, "R3 random");
  endtask

  task automatic test_noncanonical;
    vec_t x;
    for (int i = 0; i < N; i++) x[i] = Q + ((i * 7) % (128 - Q));
    run(x, 0, 0, "R7 residue");
  endtask

  task automatic test_junk_inputs;
    vec_t x;
    for (int i = 0; i < N; i++) x[i] = $urandom_range(0, Q - 1);
    run(x, 3, 1, "R6 junk ignored");
  endtask

  initial begin
    test_reset();
    test_impulse(0);
    test_impulse(5);
    test_random(0);
    test_random(2);
    test_noncanonical();
    test_junk_inputs();
    test_random(5);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule